// File: doc/BRIEF.md
# Video Memory Contention Delay Generator

This block follows the raster of a home computer in which the video fetcher and the CPU share one RAM. It counts half-cycles across each line and lines across each frame. When the CPU starts a memory access to a bank marked as shared with video, and that access falls inside the per-line fetch window, the block returns a wait count in half-cycles. The CPU clock stretcher uses that count to hold the processor off until the video fetch has had its slot.

The wait count comes from a 16-step repeating pattern. The first four steps are fixed and the other twelve can be written. The count is sampled one half-cycle into the access, which is where the memory-request strobe falls. The block also raises the frame interrupt for a fixed interval at a fixed raster position. It keeps the last data byte moved on the shared bus, so that a floating-bus read can return it.

The block advances only on half-cycle steps, which are clock edges with `hc_en` high. Position p means half-cycle p of the line. Video fetching begins at p = 12. The frame origin is line 0, p = 0, which is where the counters start after reset.

Top module: `mem_contention`

## Requirements
- R1: On every half-cycle step the line position advances by one. After the last position (2×CYC_PER_LINE−1 = 455) it returns to 0 and the line number advances. The line number returns to 0 after line LINES−1 (310 by default). When `hc_en` is low, nothing moves.
- R2: The contention window covers line positions 0 to 2×WIN_CYC−1 (0..257), which starts 12 half-cycles before the first video fetch. A sampled access outside the window gives `wait_vld`=1 with `wait_hc`=0.
- R3: Inside the window, the wait count is the pattern entry selected by the low four bits of the sampled position. Entries 0..3 are fixed at 2, 1, 0, 0.
- R4: Entries 4..15 reset to 0. A write with `tbl_we`=1 stores `tbl_val` into entry `tbl_idx`. Writes that name entries 0..3 are ignored.
- R5: An access counts as contended only when bit `addr_hi` of CONT_BANKS is set. By default only bank 1 (`addr_hi`=1) is set.
- R6: Only the cycle codes for opcode-fetch start (1), read start (2) and write start (3) produce a wait result. Idle (0), opcode data (4), read data (5), write data (6) and I/O (7) give `wait_vld`=0.
- R7: Take a start accepted on a step at position p. The wait is looked up at position p+1, modulo the line length. `wait_vld` and `wait_hc` take that result on the step after the accepting one, and both return to 0 on the next step that has no result.
- R8: `irq` rises on the step that leaves frame offset F−2×INT_LEAD_CYC+2×LEADIN_CYC, where F is the frame length in half-cycles. Frame offset means line×456+position. With the default parameters this is line 248, position 4.
- R9: `irq` stays high for exactly 2×IRQ_CYC steps (64 by default), then goes low until the next frame.
- R10: Opcode-data, read-data and write-data cycles (codes 4, 5, 6) to a contended bank load `din` into `bus_latch` on that step. Every other step leaves the latch unchanged.
- R11: During reset `wait_vld`, `wait_hc`, `irq` and `bus_latch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hc_en | input | 1 | Half-cycle step enable |
| addr_hi | input | 2 | Upper two CPU address bits (bank select) |
| cyc | input | 3 | CPU machine-cycle code |
| din | input | 8 | Data byte on the CPU bus |
| tbl_we | input | 1 | Pattern entry write strobe |
| tbl_idx | input | 4 | Pattern entry index |
| tbl_val | input | DLY_W | Pattern entry value |
| wait_vld | output | 1 | Wait result present this half-cycle |
| wait_hc | output | DLY_W | Wait count in half-cycles |
| irq | output | 1 | Frame interrupt request |
| bus_latch | output | 8 | Last byte moved on the contended bus |

## Verification
The hardest behaviour to reach is the interrupt: it fires only once per frame, and a second pulse can only be checked after a full frame of steps. The bench therefore uses a shortened frame and a smaller interrupt lead. It watches `irq` on every half-cycle across two frames, and in the second frame it runs the step enable at half rate, so both the line wrap and the pause behaviour are checked. The per-offset pattern is reached by holding a read start on consecutive steps, which produces one wait result for every position of a whole line, including the wrap back to position 0.

// File: rtl/mem_cont_pkg.sv
package mem_cont_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE      = 3'd0,
        CYC_OPC_START = 3'd1,
        CYC_RD_START  = 3'd2,
        CYC_WR_START  = 3'd3,
        CYC_OPC_DATA  = 3'd4,
        CYC_RD_DATA   = 3'd5,
        CYC_WR_DATA   = 3'd6,
        CYC_IO        = 3'd7
    } cyc_e;

    // Cycle codes that begin a memory access and may be stretched.
    function automatic logic is_start(input logic [2:0] c);
        return (c == CYC_OPC_START) || (c == CYC_RD_START) || (c == CYC_WR_START);
    endfunction

    // Cycle codes that move a data byte across the memory bus.
    function automatic logic is_data(input logic [2:0] c);
        return (c == CYC_OPC_DATA) || (c == CYC_RD_DATA) || (c == CYC_WR_DATA);
    endfunction

    // Hard-wired head of the wait pattern.
    function automatic logic [7:0] fixed_delay(input int i);
        case (i)
            0:       return 8'd2;
            1:       return 8'd1;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/mc_raster.sv
module mc_raster #(
    parameter int LINE_HC = 456,
    parameter int LINES   = 311
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    output logic [$clog2(LINE_HC)-1:0]  hpos,
    output logic [$clog2(LINES)-1:0]    line
);
    localparam int HW = $clog2(LINE_HC);
    localparam int LW = $clog2(LINES);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_HC - 1);
    localparam logic [LW-1:0] L_LAST = LW'(LINES - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [LW-1:0] l;
    } ras_t;

    ras_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (adv) begin
            if (r_q.h == H_LAST) begin
                r_d.h = '0;
                r_d.l = (r_q.l == L_LAST) ? '0 : r_q.l + 1'b1;
            end else begin
                r_d.h = r_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hpos = r_q.h;
    assign line = r_q.l;
endmodule

// File: rtl/mc_pattern.sv
module mc_pattern
    import mem_cont_pkg::*;
#(
    parameter int TAB_N   = 16,
    parameter int DLY_W   = 4,
    parameter int FIXED_N = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(TAB_N)-1:0]   widx,
    input  logic [DLY_W-1:0]           wval,
    input  logic [$clog2(TAB_N)-1:0]   ridx,
    output logic [DLY_W-1:0]           rval
);
    localparam int IW = $clog2(TAB_N);

    logic [DLY_W-1:0] ent [TAB_N];

    for (genvar i = 0; i < TAB_N; i++) begin : g_ent
        if (i < FIXED_N) begin : g_fixed
            assign ent[i] = DLY_W'(fixed_delay(i));
        end else begin : g_load
            logic [DLY_W-1:0] e_d, e_q;
            always_comb begin
                e_d = e_q;
                if (we && (widx == IW'(i))) e_d = wval;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) e_q <= '0;
                else        e_q <= e_d;
            end
            assign ent[i] = e_q;
        end
    end

    assign rval = ent[ridx];
endmodule

// File: rtl/mc_irq.sv
module mc_irq #(
    parameter int LINE_HC  = 456,
    parameter int LINES    = 311,
    parameter int INT_LINE = 248,
    parameter int INT_HPOS = 4,
    parameter int PULSE_HC = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic [$clog2(LINE_HC)-1:0]  hpos,
    input  logic [$clog2(LINES)-1:0]    line,
    output logic                        irq
);
    localparam int HW = $clog2(LINE_HC);
    localparam int LW = $clog2(LINES);
    localparam int CW = $clog2(PULSE_HC + 1);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } irq_t;

    irq_t s_d, s_q;
    logic at_mark;

    assign at_mark = (hpos == HW'(INT_HPOS)) && (line == LW'(INT_LINE));

    always_comb begin
        s_d = s_q;
        if (adv) begin
            if (at_mark) begin
                s_d.on  = 1'b1;
                s_d.cnt = CW'(PULSE_HC - 1);
            end else if (s_q.on) begin
                if (s_q.cnt == '0) s_d.on  = 1'b0;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.on;
endmodule

// File: rtl/mem_contention.sv
module mem_contention
    import mem_cont_pkg::*;
#(
    parameter int         CYC_PER_LINE = 228,
    parameter int         LINES        = 311,
    parameter int         LEADIN_CYC   = 6,
    parameter int         WIN_CYC      = 129,
    parameter int         INT_LEAD_CYC = 14368,
    parameter int         IRQ_CYC      = 32,
    parameter logic [3:0] CONT_BANKS   = 4'b0010,
    parameter int         DLY_W        = 4,
    parameter int         TAB_N        = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hc_en,
    input  logic [1:0]                 addr_hi,
    input  logic [2:0]                 cyc,
    input  logic [7:0]                 din,
    input  logic                       tbl_we,
    input  logic [$clog2(TAB_N)-1:0]   tbl_idx,
    input  logic [DLY_W-1:0]           tbl_val,
    output logic                       wait_vld,
    output logic [DLY_W-1:0]           wait_hc,
    output logic                       irq,
    output logic [7:0]                 bus_latch
);
    localparam int LINE_HC  = 2 * CYC_PER_LINE;
    localparam int WIN_HC   = 2 * WIN_CYC;
    localparam int FRAME_HC = LINE_HC * LINES;
    localparam int INT_RAW  = FRAME_HC - 2 * INT_LEAD_CYC + 2 * LEADIN_CYC;
    localparam int INT_POS  = ((INT_RAW % FRAME_HC) + FRAME_HC) % FRAME_HC;
    localparam int INT_LINE = INT_POS / LINE_HC;
    localparam int INT_HPOS = INT_POS % LINE_HC;
    localparam int IRQ_HC   = 2 * IRQ_CYC;
    localparam int HW       = $clog2(LINE_HC);
    localparam int LW       = $clog2(LINES);
    localparam int IW       = $clog2(TAB_N);

    typedef struct packed {
        logic             pend;
        logic             wvld;
        logic [DLY_W-1:0] whc;
        logic [7:0]       latch;
    } st_t;

    st_t s_d, s_q;

    logic [HW-1:0]    hpos;
    logic [LW-1:0]    line;
    logic [DLY_W-1:0] pat_val;
    logic             bank_hit, start_hit, data_hit, in_win, pend_w;

    mc_raster #(.LINE_HC(LINE_HC), .LINES(LINES)) u_raster (
        .clk(clk), .rst_n(rst_n), .adv(hc_en), .hpos(hpos), .line(line)
    );

    mc_pattern #(.TAB_N(TAB_N), .DLY_W(DLY_W), .FIXED_N(4)) u_pattern (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wval(tbl_val),
        .ridx(hpos[IW-1:0]), .rval(pat_val)
    );

    mc_irq #(
        .LINE_HC(LINE_HC), .LINES(LINES), .INT_LINE(INT_LINE),
        .INT_HPOS(INT_HPOS), .PULSE_HC(IRQ_HC)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .adv(hc_en), .hpos(hpos), .line(line), .irq(irq)
    );

    assign bank_hit  = CONT_BANKS[addr_hi];
    assign start_hit = bank_hit && is_start(cyc);
    assign data_hit  = bank_hit && is_data(cyc);
    // Window opens at line position 0, so the pattern index is the low bits of hpos.
    assign in_win    = int'(hpos) < WIN_HC;

    always_comb begin
        s_d = s_q;
        if (hc_en) begin
            s_d.pend = start_hit;
            s_d.wvld = s_q.pend;
            s_d.whc  = (s_q.pend && in_win) ? pat_val : '0;
            if (data_hit) s_d.latch = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_w    = s_q.pend;
    assign wait_vld  = s_q.wvld;
    assign wait_hc   = s_q.whc;
    assign bus_latch = s_q.latch;
endmodule

// File: rtl/mc_chk.sv
module mc_chk
    import mem_cont_pkg::*;
#(
    parameter int         LINE_HC    = 456,
    parameter int         LINES      = 311,
    parameter int         WIN_HC     = 258,
    parameter int         IRQ_HC     = 64,
    parameter logic [3:0] CONT_BANKS = 4'b0010,
    parameter int         DLY_W      = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        hc_en,
    input logic [1:0]                  addr_hi,
    input logic [2:0]                  cyc,
    input logic                        wait_vld,
    input logic [DLY_W-1:0]            wait_hc,
    input logic                        irq,
    input logic [7:0]                  bus_latch,
    input logic [$clog2(LINE_HC)-1:0]  hpos,
    input logic [$clog2(LINES)-1:0]    line,
    input logic                        pend
);
    localparam int HW = $clog2(LINE_HC);
    localparam int LW = $clog2(LINES);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_HC - 1);
    localparam logic [LW-1:0] L_LAST = LW'(LINES - 1);

    int unsigned irq_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     irq_run <= 0;
        else if (!irq)  irq_run <= 0;
        else if (hc_en) irq_run <= irq_run + 1;
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos <= H_LAST) && (line <= L_LAST));  // R1
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hc_en |=> $stable(hpos) && $stable(line) && $stable(irq) && $stable(wait_vld));  // R1
    AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        hc_en && (hpos != H_LAST) |=> hpos == $past(hpos) + 1'b1);  // R1
    AST_OUT_WIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hc_en && pend && (int'(hpos) >= WIN_HC) |=> wait_hc == '0);  // R2
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        hc_en |=> wait_vld == $past(pend));  // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_vld |-> wait_hc == '0);  // R7
    AST_START_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        hc_en && !(CONT_BANKS[addr_hi] && is_start(cyc)) |=> !pend);  // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hc_en && CONT_BANKS[addr_hi] && is_data(cyc)) |=> $stable(bus_latch));  // R10
    AST_IRQ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_run <= IRQ_HC);  // R9
endmodule

bind mem_contention mc_chk #(
    .LINE_HC(LINE_HC), .LINES(LINES), .WIN_HC(WIN_HC), .IRQ_HC(IRQ_HC),
    .CONT_BANKS(CONT_BANKS), .DLY_W(DLY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hc_en(hc_en), .addr_hi(addr_hi), .cyc(cyc),
    .wait_vld(wait_vld), .wait_hc(wait_hc), .irq(irq), .bus_latch(bus_latch),
    .hpos(hpos), .line(line), .pend(pend_w)
);

// File: tb/sim_mem_contention.sv
`timescale 1ns/1ps
module sim_mem_contention;
    localparam int LINE_HC  = 456;
    localparam int LINES    = 64;
    localparam int FRAME    = LINE_HC * LINES;
    localparam int INT_LEAD = 2000;
    localparam int INT_POS  = FRAME - 2 * INT_LEAD + 12;
    localparam int WIN_HC   = 258;
    localparam int IRQ_HC   = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hc_en = 1'b0;
    logic [1:0] addr_hi = 2'd0;
    logic [2:0] cyc = 3'd0;
    logic [7:0] din = 8'd0;
    logic       tbl_we = 1'b0;
    logic [3:0] tbl_idx = 4'd0;
    logic [3:0] tbl_val = 4'd0;
    logic       wait_vld, irq;
    logic [3:0] wait_hc;
    logic [7:0] bus_latch;

    int  edges = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  loaded = 0;
    bit  ended = 0;

    mem_contention #(.LINES(LINES), .INT_LEAD_CYC(INT_LEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .hc_en(hc_en), .addr_hi(addr_hi), .cyc(cyc),
        .din(din), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_val(tbl_val),
        .wait_vld(wait_vld), .wait_hc(wait_hc), .irq(irq), .bus_latch(bus_latch)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n && hc_en) edges <= edges + 1;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pat(input int i);
        if (i == 0) return 2;
        if (i == 1) return 1;
        if (i < 4)  return 0;
        return loaded ? i - 3 : 0;
    endfunction

    function automatic int exp_wait(input int p);
        return (p < WIN_HC) ? pat(p % 16) : 0;
    endfunction

    function automatic int exp_irq(input int e);
        if (e <= INT_POS) return 0;
        return (((e - 1 - INT_POS) % FRAME) < IRQ_HC) ? 1 : 0;
    endfunction

    // Start presented at position o-1, so the lookup lands on position o.
    task automatic sample_at(input int o, input logic [1:0] bank, input logic [2:0] c,
                             input int ev, input int eh, input string req);
        while ((edges % LINE_HC) != ((o + LINE_HC - 1) % LINE_HC)) @(negedge clk);
        addr_hi = bank; cyc = c;
        @(negedge clk);
        cyc = 3'd0;
        @(negedge clk);
        check(req, int'(wait_vld), ev);
        check(req, int'(wait_hc), eh);
    endtask

    task automatic t_reset;
        check("R11", int'(wait_vld), 0);
        check("R11", int'(wait_hc), 0);
        check("R11", int'(irq), 0);
        check("R11", int'(bus_latch), 0);
    endtask

    task automatic t_pattern_reset;
        sample_at(4, 2'd1, 3'd2, 1, 0, "R4");
        sample_at(7, 2'd1, 3'd2, 1, 0, "R4");
        sample_at(0, 2'd1, 3'd2, 1, 2, "R3");
        sample_at(1, 2'd1, 3'd2, 1, 1, "R3");
    endtask

    task automatic t_load;
        for (int i = 4; i < 16; i++) begin
            tbl_we = 1'b1; tbl_idx = 4'(i); tbl_val = 4'(i - 3);
            @(negedge clk);
        end
        tbl_we = 1'b1; tbl_idx = 4'd1; tbl_val = 4'd9;
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'd3; tbl_val = 4'd7;
        @(negedge clk);
        tbl_we = 1'b0;
        loaded = 1;
        sample_at(1, 2'd1, 3'd2, 1, 1, "R4");
        sample_at(3, 2'd1, 3'd2, 1, 0, "R4");
        sample_at(9, 2'd1, 3'd2, 1, 6, "R4");
    endtask

    task automatic t_sweep;
        while ((edges % LINE_HC) != LINE_HC - 1) @(negedge clk);
        addr_hi = 2'd1; cyc = 3'd2;
        for (int i = 0; i <= LINE_HC + 1; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                check("R3", int'(wait_vld), 1);
                check("R3", int'(wait_hc), exp_wait((edges - 1) % LINE_HC));
            end
        end
        cyc = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check("R7", int'(wait_vld), 0);
        check("R7", int'(wait_hc), 0);
    endtask

    task automatic t_window_edges;
        sample_at(256, 2'd1, 3'd2, 1, 2, "R2");
        sample_at(257, 2'd1, 3'd2, 1, 1, "R2");
        sample_at(258, 2'd1, 3'd2, 1, 0, "R2");
        sample_at(400, 2'd1, 3'd2, 1, 0, "R2");
        sample_at(11, 2'd1, 3'd2, 1, 8, "R2");
        sample_at(0, 2'd1, 3'd2, 1, 2, "R7");
    endtask

    task automatic t_types;
        sample_at(20, 2'd1, 3'd1, 1, 1, "R6");
        sample_at(21, 2'd1, 3'd3, 1, 2, "R6");
        sample_at(22, 2'd1, 3'd7, 0, 0, "R6");
        sample_at(23, 2'd1, 3'd5, 0, 0, "R6");
        sample_at(24, 2'd1, 3'd6, 0, 0, "R6");
        sample_at(25, 2'd0, 3'd2, 0, 0, "R5");
        sample_at(26, 2'd2, 3'd1, 0, 0, "R5");
        sample_at(27, 2'd3, 3'd3, 0, 0, "R5");
    endtask

    task automatic t_gate;
        hc_en = 1'b0; addr_hi = 2'd1; cyc = 3'd2;
        @(negedge clk);
        @(negedge clk);
        hc_en = 1'b1; cyc = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check("R1", int'(wait_vld), 0);
        sample_at(30, 2'd1, 3'd2, 1, 11, "R1");
    endtask

    task automatic latch_step(input logic en, input logic [1:0] bank, input logic [2:0] c,
                              input logic [7:0] d, input int exp);
        hc_en = en; addr_hi = bank; cyc = c; din = d;
        @(negedge clk);
        hc_en = 1'b1; cyc = 3'd0; din = 8'd0;
        @(negedge clk);
        check("R10", int'(bus_latch), exp);
    endtask

    task automatic t_latch;
        latch_step(1'b1, 2'd1, 3'd5, 8'hA5, 8'hA5);
        latch_step(1'b1, 2'd0, 3'd6, 8'h3C, 8'hA5);
        latch_step(1'b1, 2'd1, 3'd7, 8'hC3, 8'hA5);
        latch_step(1'b1, 2'd1, 3'd2, 8'h11, 8'hA5);
        latch_step(1'b1, 2'd1, 3'd6, 8'h5A, 8'h5A);
        latch_step(1'b1, 2'd1, 3'd4, 8'h77, 8'h77);
        latch_step(1'b0, 2'd1, 3'd6, 8'h99, 8'h77);
    endtask

    task automatic t_irq;
        while (edges < INT_POS + FRAME + 100) begin
            @(negedge clk);
            if (edges >= FRAME) hc_en = ~hc_en;
            check((exp_irq(edges) == 1 && ((edges - 1 - INT_POS) % FRAME) > 0) ? "R9" : "R8",
                  int'(irq), exp_irq(edges));
        end
        hc_en = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        hc_en = 1'b1;
        t_pattern_reset;
        t_load;
        t_sweep;
        t_window_edges;
        t_types;
        t_gate;
        t_latch;
        t_irq;
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 195000);
        if (!ended) begin
            ended = 1;
            check("watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule